// File: doc/BRIEF.md
# Token-Synchronized Read/Execute/Write Node Controller

This block is the control core of one pipelined processing node. It has two read units, one execution unit and two write units. A dispatcher hands each incoming operation to one of them. The units do not talk to each other directly: they coordinate through token slots that each hold one token. A read unit pulls one item from its input channel and then drops a token into its slot toward the execution unit.

An execute operation carries two masks:
- an input mask, naming the read slots whose tokens it needs;
- an output mask, naming the write units that wait on its result.

The execute fires in a single cycle once every named input token is present and every named output slot is empty. At that moment it takes all of the named input tokens together and fills all of the named output slots. A write unit pushes to its output channel only when it holds its token and the channel is ready.

Because the token slots are bounded, the reads of the next iteration can run while the current iteration is still writing. How much of that overlap is allowed is set by an outstanding-operation window. The window counts operations that have been dispatched but not finished. Each unit acknowledges to the dispatcher when its operation completes, and the acknowledgment frees one window place. A window of one makes the node handle its operations one at a time.

Top module: `rxw_node`

Every unit is a two-state machine: **IDLE** (free) and **WAIT** (holding an accepted operation).
- IDLE→WAIT is the *accept* transition: the dispatcher starts the unit.
- WAIT→IDLE is the *complete* transition. A read completes on a take, an execute on a fire, a write on a push. A completion is also the unit's acknowledgment to the dispatcher.

## Requirements
- R1: After reset the following hold:
  - `in_take`, `out_push` and `exec_fire` are all zero;
  - every token slot is empty;
  - the window is empty;
  - `op_ready` is high for an operation aimed at an idle unit.
- R2: A read unit in WAIT whose source has `in_valid` high and whose token slot is empty pulses `in_take` for that channel in that cycle. Its token slot is full from the next cycle on.
- R3: A read unit whose token slot is full does not take from its source. It stays in WAIT, so a further read to the same unit sees `op_ready` low, until the execute consumes the token.
- R4: The execution unit fires (`exec_fire` high) only while every read slot named in its input mask holds a token. In the fire cycle it clears exactly those slots.
- R5: The execution unit does not fire while any write slot named in its output mask is full. In the fire cycle it fills every slot named in its output mask.
- R6: A write unit in WAIT pulses `out_push` only while it holds its token and `out_ready` is high. The push empties its slot.
- R7: Operations are routed by `op_kind` and `op_chan`. The `op_kind` encodings are 0 = read, 1 = execute, 2 = write and 3 = reserved. For reads and writes, `op_chan` selects the unit. `op_ready` is low while the addressed unit is in WAIT.
- R8: At most WIN operations are outstanding. When WIN are outstanding, `op_ready` is low for reads, executes and writes. Each completion frees one place from the next cycle on.
- R9: An operation with the reserved code 3 is always accepted. It is then dropped: it starts no unit and takes no window place.
- R10: An execute is never fired in the cycle in which it is accepted. With an input mask of zero and free output slots, it fires in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The offered operation is accepted this cycle |
| op_kind | input | 2 | Operation kind: 0 read, 1 execute, 2 write, 3 reserved |
| op_chan | input | CHW | Read or write unit index |
| op_in_mask | input | NRD | Execute input mask, one bit per read slot |
| op_out_mask | input | NWR | Execute output mask, one bit per write slot |
| in_valid | input | NRD | Source channel has an item, per read unit |
| in_take | output | NRD | Read unit takes an item this cycle |
| out_ready | input | NWR | Sink channel has room, per write unit |
| out_push | output | NWR | Write unit pushes an item this cycle |
| exec_fire | output | 1 | Execute operation performed this cycle |

## Verification
The assertions check the token rules on every cycle:
- a read slot fills only after a take;
- a read slot empties only through a fire whose input mask names it;
- a write slot empties only through a push;
- the window count never exceeds WIN;
- no execute fires in the cycle in which it is accepted.

Some behaviours only the bench's scenarios can show. These are the overlap of iterations in a stream, a read held back by a full slot, an execute held back by a full output slot, dispatch refused because the window is full, and the dropping of the reserved code. For these, the bench's behavioural model predicts `in_take`, `exec_fire`, `out_push` and `op_ready` on every cycle.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_EXEC  = 2'd1,
        K_WRITE = 2'd2,
        K_NOP   = 2'd3
    } op_kind_e;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_WAIT = 1'b1
    } unit_st_e;
endpackage

// File: rtl/rxw_rd_unit.sv
module rxw_rd_unit
    import rxw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic src_valid,
    input  logic tok_full,
    output logic busy,
    output logic take
);
    unit_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= U_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (start) state_d = U_WAIT;
            U_WAIT: if (take)  state_d = U_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == U_WAIT);
        take = (state_q == U_WAIT) && src_valid && !tok_full;
    end

    // R3: a full slot blocks the fetch
    assert_stall_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tok_full |-> !take);
endmodule

// File: rtl/rxw_ex_unit.sv
module rxw_ex_unit
    import rxw_pkg::*;
#(
    parameter int NRD = 2,
    parameter int NWR = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NRD-1:0] in_mask,
    input  logic [NWR-1:0] out_mask,
    input  logic [NRD-1:0] rtok,
    input  logic [NWR-1:0] wtok,
    output logic           busy,
    output logic           fire,
    output logic [NRD-1:0] consume,
    output logic [NWR-1:0] produce
);
    unit_st_e       state_q, state_d;
    logic [NRD-1:0] need_q;
    logic [NWR-1:0] feed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            need_q  <= '0;
            feed_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                need_q <= in_mask;
                feed_q <= out_mask;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (start) state_d = U_WAIT;
            U_WAIT: if (fire)  state_d = U_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q == U_WAIT);
        fire    = (state_q == U_WAIT) && ((need_q & ~rtok) == '0)
                  && ((feed_q & wtok) == '0);
        consume = fire ? need_q : '0;
        produce = fire ? feed_q : '0;
    end

    // R10: no fire in the acceptance cycle
    assert_no_fire_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !fire);
endmodule

// File: rtl/rxw_wr_unit.sv
module rxw_wr_unit
    import rxw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tok,
    input  logic sink_ready,
    output logic busy,
    output logic push
);
    unit_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= U_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (start) state_d = U_WAIT;
            U_WAIT: if (push)  state_d = U_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == U_WAIT);
        push = (state_q == U_WAIT) && tok && sink_ready;
    end
endmodule

// File: rtl/rxw_node.sv
module rxw_node
    import rxw_pkg::*;
#(
    parameter int NRD = 2,
    parameter int NWR = 2,
    parameter int WIN = 4,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    output logic           op_ready,
    input  logic [1:0]     op_kind,
    input  logic [CHW-1:0] op_chan,
    input  logic [NRD-1:0] op_in_mask,
    input  logic [NWR-1:0] op_out_mask,
    input  logic [NRD-1:0] in_valid,
    output logic [NRD-1:0] in_take,
    input  logic [NWR-1:0] out_ready,
    output logic [NWR-1:0] out_push,
    output logic           exec_fire
);
    localparam int CNTW = $clog2(WIN + 1);

    op_kind_e       kind;
    logic [NRD-1:0] rd_busy, rd_start, rtok_q, consume;
    logic [NWR-1:0] wr_busy, wr_start, wtok_q, produce;
    logic           ex_busy, ex_start, tgt_idle, room, accept;
    logic [CNTW-1:0] cnt_q;
    int             n_ack;

    assign kind = op_kind_e'(op_kind);

    // dispatcher
    always_comb begin
        tgt_idle = 1'b0;
        unique case (kind)
            K_READ:  tgt_idle = (int'(op_chan) < NRD) && !rd_busy[op_chan];
            K_EXEC:  tgt_idle = !ex_busy;
            K_WRITE: tgt_idle = (int'(op_chan) < NWR) && !wr_busy[op_chan];
            K_NOP:   tgt_idle = 1'b1;
        endcase
        room     = int'(cnt_q) < WIN;
        op_ready = (kind == K_NOP) || (room && tgt_idle);
        accept   = op_valid && op_ready && (kind != K_NOP);
        ex_start = accept && (kind == K_EXEC);
    end

    genvar g;
    generate
        for (g = 0; g < NRD; g++) begin : g_rd
            assign rd_start[g] = accept && (kind == K_READ) && (int'(op_chan) == g);
            rxw_rd_unit u_rd (
                .clk(clk), .rst_n(rst_n), .start(rd_start[g]),
                .src_valid(in_valid[g]), .tok_full(rtok_q[g]),
                .busy(rd_busy[g]), .take(in_take[g])
            );
            always_ff @(posedge clk) begin
                if (!rst_n)           rtok_q[g] <= 1'b0;
                else if (in_take[g])  rtok_q[g] <= 1'b1;
                else if (consume[g])  rtok_q[g] <= 1'b0;
            end
            // R2: a read slot fills only through a take
            assert_rtok_from_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rtok_q[g]) |-> $past(in_take[g]));
            // R4: a read slot empties only through a fire naming it
            assert_rtok_by_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rtok_q[g]) |-> $past(exec_fire && consume[g]));
        end

        for (g = 0; g < NWR; g++) begin : g_wr
            assign wr_start[g] = accept && (kind == K_WRITE) && (int'(op_chan) == g);
            rxw_wr_unit u_wr (
                .clk(clk), .rst_n(rst_n), .start(wr_start[g]),
                .tok(wtok_q[g]), .sink_ready(out_ready[g]),
                .busy(wr_busy[g]), .push(out_push[g])
            );
            always_ff @(posedge clk) begin
                if (!rst_n)           wtok_q[g] <= 1'b0;
                else if (produce[g])  wtok_q[g] <= 1'b1;
                else if (out_push[g]) wtok_q[g] <= 1'b0;
            end
            // R6: a write slot empties only through a push
            assert_wtok_by_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(wtok_q[g]) |-> $past(out_push[g]));
        end
    endgenerate

    rxw_ex_unit #(.NRD(NRD), .NWR(NWR)) u_ex (
        .clk(clk), .rst_n(rst_n), .start(ex_start),
        .in_mask(op_in_mask), .out_mask(op_out_mask),
        .rtok(rtok_q), .wtok(wtok_q), .busy(ex_busy),
        .fire(exec_fire), .consume(consume), .produce(produce)
    );

    // outstanding window
    always_comb begin
        n_ack = int'(exec_fire);
        for (int i = 0; i < NRD; i++) n_ack += int'(in_take[i]);
        for (int i = 0; i < NWR; i++) n_ack += int'(out_push[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= CNTW'(int'(cnt_q) + int'(accept) - n_ack);
    end

    // R8: window never exceeds its size
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= WIN);
endmodule

// File: tb/sim_rxw_node.sv
module sim_rxw_node;
    localparam int WIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [1:0] op_kind = 2'd0;
    logic [0:0] op_chan = 1'b0;
    logic [1:0] op_in_mask = 2'b00, op_out_mask = 2'b00;
    logic [1:0] in_valid = 2'b00, in_take;
    logic [1:0] out_ready = 2'b00, out_push;
    logic       exec_fire;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference model state
    bit [1:0] m_rpend = 0, m_rtok = 0, m_wpend = 0, m_wtok = 0, m_ein = 0, m_eout = 0;
    bit       m_epend = 0;
    int       m_cnt = 0;
    bit       last_acc;

    always #5 clk = ~clk;

    rxw_node #(.WIN(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_chan(op_chan), .op_in_mask(op_in_mask),
        .op_out_mask(op_out_mask), .in_valid(in_valid), .in_take(in_take),
        .out_ready(out_ready), .out_push(out_push), .exec_fire(exec_fire)
    );

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // compare this cycle against the model, then advance the model one clock
    task automatic tick();
        bit [1:0] e_take, e_push, acc_r, acc_w;
        bit       e_fire, idle, e_ready, acc;
        int       nack;
        #1;
        e_take = m_rpend & in_valid & ~m_rtok;
        e_fire = m_epend && ((m_ein & ~m_rtok) == 0) && ((m_eout & m_wtok) == 0);
        e_push = m_wpend & m_wtok & out_ready;
        case (op_kind)
            2'd0:    idle = !m_rpend[op_chan];
            2'd1:    idle = !m_epend;
            2'd2:    idle = !m_wpend[op_chan];
            default: idle = 1'b1;
        endcase
        e_ready = (op_kind == 2'd3) ? 1'b1 : ((m_cnt < WIN) && idle);
        chk("R2 in_take", in_take, e_take);
        chk("R4 exec_fire", {1'b0, exec_fire}, {1'b0, e_fire});
        chk("R6 out_push", out_push, e_push);
        chk("R7 op_ready", {1'b0, op_ready}, {1'b0, e_ready});
        last_acc = op_valid && e_ready;
        acc   = last_acc && (op_kind != 2'd3);
        acc_r = (acc && op_kind == 2'd0) ? (2'b01 << op_chan) : 2'b00;
        acc_w = (acc && op_kind == 2'd2) ? (2'b01 << op_chan) : 2'b00;
        nack  = int'(e_fire) + $countones(e_take) + $countones(e_push);
        m_rtok  = (m_rtok | e_take) & ~(e_fire ? m_ein : 2'b00);
        m_wtok  = (m_wtok | (e_fire ? m_eout : 2'b00)) & ~e_push;
        m_rpend = (m_rpend & ~e_take) | acc_r;
        m_wpend = (m_wpend & ~e_push) | acc_w;
        if (e_fire) m_epend = 0;
        if (acc && op_kind == 2'd1) begin
            m_epend = 1; m_ein = op_in_mask; m_eout = op_out_mask;
        end
        m_cnt = m_cnt + int'(acc) - nack;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(logic [1:0] k, logic c, logic [1:0] im, logic [1:0] om);
        op_kind = k; op_chan = c; op_in_mask = im; op_out_mask = om; op_valid = 1'b1;
        for (int n = 0; n < 100; n++) begin
            tick();
            if (last_acc) break;
        end
        op_valid = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet outputs and ready after reset
        chk("R1 in_take", in_take, 2'b00);
        chk("R1 out_push", out_push, 2'b00);
        chk("R1 exec_fire", {1'b0, exec_fire}, 2'b00);
        chk("R1 op_ready", {1'b0, op_ready}, 2'b01);
        @(negedge clk);

        // streaming iterations: reads overlap with writes of the previous one
        in_valid = 2'b11; out_ready = 2'b11;
        for (int it = 0; it < 3; it++) begin
            issue(2'd0, 1'b0, 2'b00, 2'b00);
            issue(2'd0, 1'b1, 2'b00, 2'b00);
            issue(2'd1, 1'b0, 2'b11, 2'b11);
            issue(2'd2, 1'b0, 2'b00, 2'b00);
            issue(2'd2, 1'b1, 2'b00, 2'b00);
        end
        idle_cycles(4);

        // R10: empty-mask execute fires the first cycle after acceptance
        issue(2'd1, 1'b0, 2'b00, 2'b00);
        #1 chk("R10 fire after accept", {1'b0, exec_fire}, 2'b01);
        idle_cycles(2);

        // R3: full read slot stalls the read unit
        out_ready = 2'b00;
        issue(2'd0, 1'b0, 2'b00, 2'b00);
        idle_cycles(1);
        issue(2'd0, 1'b0, 2'b00, 2'b00);
        #1 chk("R3 no take while full", {1'b0, in_take[0]}, 2'b00);
        op_kind = 2'd0; op_chan = 1'b0;
        #1 chk("R3 unit busy", {1'b0, op_ready}, 2'b00);
        idle_cycles(2);
        issue(2'd1, 1'b0, 2'b01, 2'b00);
        idle_cycles(3);
        issue(2'd1, 1'b0, 2'b01, 2'b00);
        idle_cycles(3);

        // R8: window full with four blocked operations
        in_valid = 2'b00;
        issue(2'd0, 1'b0, 2'b00, 2'b00);
        issue(2'd0, 1'b1, 2'b00, 2'b00);
        issue(2'd2, 1'b0, 2'b00, 2'b00);
        issue(2'd2, 1'b1, 2'b00, 2'b00);
        op_kind = 2'd1;
        #1 chk("R8 window full", {1'b0, op_ready}, 2'b00);
        idle_cycles(2);

        // R5: output slot full holds the execute
        in_valid = 2'b11;
        idle_cycles(2);
        issue(2'd1, 1'b0, 2'b11, 2'b01);
        idle_cycles(1);
        issue(2'd1, 1'b0, 2'b00, 2'b01);
        for (int i = 0; i < 3; i++) begin
            #1 chk("R5 held by full slot", {1'b0, exec_fire}, 2'b00);
            tick();
        end
        out_ready = 2'b11;
        idle_cycles(3);
        issue(2'd2, 1'b0, 2'b00, 2'b00);
        issue(2'd1, 1'b0, 2'b00, 2'b10);
        idle_cycles(4);

        // R9: reserved code accepted and dropped
        op_kind = 2'd3;
        #1 chk("R9 reserved accepted", {1'b0, op_ready}, 2'b01);
        issue(2'd3, 1'b0, 2'b11, 2'b11);
        idle_cycles(3);
        #1 chk("R9 no effect", {exec_fire, out_push[0]}, 2'b00);
        idle_cycles(2);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule